// File: doc/BRIEF.md
# DMA Channel Control and Request Arbitration

This block is the control-and-status section of a four-channel DMA controller. It accepts single-byte register writes and reads addressed by a 4-bit control index. Only indices 8 to 15 (index bit 3 set) are decoded. From these accesses it maintains the per-channel mask bits, the request and terminal-count status bits, one mode byte per channel and the command byte. It also produces a strobe that tells the address/count section to reset its byte pointer.

Three further inputs come from the surrounding controller. The external request lines can raise or drop a channel's request bit. The transfer engine reports terminal count per channel. From the mask and request bits the block produces a registered, one-hot service grant that picks the lowest-numbered eligible channel. Moving data is done elsewhere; this block only decides which channel may be served.

Top module: `dmac_control`

## Requirements
- R1: After reset all mask bits are 1; status, command, every mode byte and the grant are 0.
- R2: A write at index 8 stores the data as the command byte only if the data is 0 or has no bit set other than bit 2. Any other value leaves the command byte unchanged.
- R3: A write at index 9 picks a channel with data[1:0]. It sets that channel's request bit (status bit channel+4) when data[2]=1 and clears it when data[2]=0. It always clears that channel's terminal-count bit (status bit channel).
- R4: A write at index 10 picks a channel with data[1:0] and copies data[2] into that channel's mask bit (mask_o bit channel).
- R5: A write at index 11 picks a channel with data[1:0] and stores the whole data byte as that channel's mode byte, at mode_o[8*channel+7 : 8*channel]. Other channels keep their mode bytes.
- R6: ptr_clr_o is high in exactly the cycles in which a write to index 12 or 13 is presented, and low for every other access.
- R7: A write at index 13 sets every mask bit and zeroes the command byte and the status byte. Mode bytes are kept.
- R8: A write at index 14 clears all mask bits. A write at index 15 loads mask bit n from data bit n.
- R9: rd_data is valid in the cycle rd_en is high. Index 8 returns the status byte, and the terminal-count nibble (status bits 3:0) is cleared at that clock edge. Index 15 returns the mask zero-extended. Every other index returns 0.
- R10: A tc_done pulse on channel n sets status bit n. In the same cycle it wins over a clear caused by a status read, a request write or a master reset.
- R11: A req_set pulse on channel n sets status bit n+4 and a req_clr pulse clears it. If both are high, the bit is set. Both take precedence over a software write in the same cycle.
- R12: grant_o is one-hot or zero. It marks the lowest-numbered channel whose mask bit is 0 and whose request bit is 1, and it follows a change of mask or status one clock later.
- R13: Writes and reads with index bit 3 clear change no state, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| idx | input | 4 | Control index |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data, valid while rd_en is high |
| req_set | input | NUM_CH | External request hold, one bit per channel |
| req_clr | input | NUM_CH | External request release, one bit per channel |
| tc_done | input | NUM_CH | Terminal-count event from the transfer engine |
| mask_o | output | NUM_CH | Channel mask bits |
| status_o | output | 2*NUM_CH | Status: request bits high, terminal-count bits low |
| cmd_o | output | DW | Command byte |
| mode_o | output | NUM_CH*DW | Mode bytes, channel 0 in the lowest byte |
| ptr_clr_o | output | 1 | Byte-pointer clear strobe |
| grant_o | output | NUM_CH | Registered one-hot service grant |

## Verification
The bench builds the block with its defaults: four channels and an 8-bit data bus. With these values the channel fields in data[1:0] reach every channel, and the status byte fills the read bus exactly. Every priority case of the grant can then be reached: two requests where the lower one wins, masking the winner so the grant moves up, and a request dropping out. The same-cycle races between terminal-count events, status reads and request writes are driven on purpose, so the precedence rules are checked directly.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  // low three bits of a control index (index bit 3 set)
  typedef enum logic [2:0] {
    OP_CMD   = 3'd0,
    OP_REQ   = 3'd1,
    OP_SMASK = 3'd2,
    OP_MODE  = 3'd3,
    OP_PCLR  = 3'd4,
    OP_MRST  = 3'd5,
    OP_CLRM  = 3'd6,
    OP_WRM   = 3'd7
  } ctl_op_e;

  // only this command bit may be set for a command write to be taken
  localparam int unsigned CMD_ALLOWED = 4;
  // data bit that carries set/clear for request and single-mask writes
  localparam int unsigned FLAG_BIT = 2;
endpackage

// File: rtl/dmac_decode.sv
`timescale 1ns/1ps
module dmac_decode
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        idx,
  input  logic [DW-1:0]     wr_data,
  output logic              cmd_we,
  output logic              req_we,
  output logic              smask_we,
  output logic              mode_we,
  output logic              pclr,
  output logic              mrst,
  output logic              clrm,
  output logic              wrm,
  output logic              rd_stat,
  output logic              rd_mask,
  output logic [NUM_CH-1:0] ch_sel
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [DW-1:0] CMD_OK = DW'(CMD_ALLOWED);

  ctl_op_e op;
  logic    wsel, rsel, cmd_ok;

  assign op     = ctl_op_e'(idx[2:0]);
  assign wsel   = wr_en & idx[3];
  assign rsel   = rd_en & idx[3];
  assign cmd_ok = (wr_data & ~CMD_OK) == '0;

  assign cmd_we   = wsel && (op == OP_CMD) && cmd_ok;
  assign req_we   = wsel && (op == OP_REQ);
  assign smask_we = wsel && (op == OP_SMASK);
  assign mode_we  = wsel && (op == OP_MODE);
  assign mrst     = wsel && (op == OP_MRST);
  assign pclr     = wsel && ((op == OP_PCLR) || (op == OP_MRST));
  assign clrm     = wsel && (op == OP_CLRM);
  assign wrm      = wsel && (op == OP_WRM);
  assign rd_stat  = rsel && (op == OP_CMD);
  assign rd_mask  = rsel && (op == OP_WRM);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_sel[i] = (wr_data[CH_W-1:0] == CH_W'(i));
  end
endmodule

// File: rtl/dmac_chan_regs.sv
`timescale 1ns/1ps
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        wr_data,
  input  logic [NUM_CH-1:0]    ch_sel,
  input  logic                 req_we,
  input  logic                 smask_we,
  input  logic                 mode_we,
  input  logic                 mrst,
  input  logic                 clrm,
  input  logic                 wrm,
  input  logic                 rd_stat,
  input  logic [NUM_CH-1:0]    req_set,
  input  logic [NUM_CH-1:0]    req_clr,
  input  logic [NUM_CH-1:0]    tc_done,
  output logic [NUM_CH-1:0]    mask_q,
  output logic [NUM_CH-1:0]    req_q,
  output logic [NUM_CH-1:0]    tc_q,
  output logic [NUM_CH*DW-1:0] mode_q
);
  logic flag;
  assign flag = wr_data[FLAG_BIT];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic          mask_d, req_d, tc_d;
    logic [DW-1:0] mode_r;

    always_comb begin
      mask_d = mask_q[i];
      if (mrst)                       mask_d = 1'b1;
      else if (clrm)                  mask_d = 1'b0;
      else if (wrm)                   mask_d = wr_data[i];
      else if (smask_we && ch_sel[i]) mask_d = flag;
    end

    always_comb begin
      req_d = req_q[i];
      if (mrst)                     req_d = 1'b0;
      else if (req_we && ch_sel[i]) req_d = flag;
      if (req_set[i])               req_d = 1'b1;
      else if (req_clr[i])          req_d = 1'b0;
    end

    always_comb begin
      tc_d = tc_q[i];
      if (mrst || rd_stat || (req_we && ch_sel[i])) tc_d = 1'b0;
      if (tc_done[i])                               tc_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[i] <= 1'b1;
        req_q[i]  <= 1'b0;
        tc_q[i]   <= 1'b0;
        mode_r    <= '0;
      end else begin
        mask_q[i] <= mask_d;
        req_q[i]  <= req_d;
        tc_q[i]   <= tc_d;
        if (mode_we && ch_sel[i]) mode_r <= wr_data;
      end
    end

    assign mode_q[i*DW +: DW] = mode_r;
  end
endmodule

// File: rtl/dmac_arbiter.sv
`timescale 1ns/1ps
module dmac_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mask_q,
  input  logic [NUM_CH-1:0] req_q,
  output logic [NUM_CH-1:0] grant_q
);
  logic [NUM_CH-1:0] elig, pick;

  assign elig = req_q & ~mask_q;

  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) pick = NUM_CH'(1) << i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= pick;
  end
endmodule

// File: rtl/dmac_control.sv
`timescale 1ns/1ps
module dmac_control #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [3:0]           idx,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  input  logic [NUM_CH-1:0]    req_set,
  input  logic [NUM_CH-1:0]    req_clr,
  input  logic [NUM_CH-1:0]    tc_done,
  output logic [NUM_CH-1:0]    mask_o,
  output logic [2*NUM_CH-1:0]  status_o,
  output logic [DW-1:0]        cmd_o,
  output logic [NUM_CH*DW-1:0] mode_o,
  output logic                 ptr_clr_o,
  output logic [NUM_CH-1:0]    grant_o
);
  logic              cmd_we, req_we, smask_we, mode_we;
  logic              pclr, mrst, clrm, wrm, rd_stat, rd_mask;
  logic [NUM_CH-1:0] ch_sel, req_q, tc_q;
  logic [DW-1:0]     cmd_q;

  dmac_decode #(.NUM_CH(NUM_CH), .DW(DW)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .idx(idx), .wr_data(wr_data),
    .cmd_we(cmd_we), .req_we(req_we), .smask_we(smask_we), .mode_we(mode_we),
    .pclr(pclr), .mrst(mrst), .clrm(clrm), .wrm(wrm),
    .rd_stat(rd_stat), .rd_mask(rd_mask), .ch_sel(ch_sel)
  );

  dmac_chan_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .ch_sel(ch_sel),
    .req_we(req_we), .smask_we(smask_we), .mode_we(mode_we),
    .mrst(mrst), .clrm(clrm), .wrm(wrm), .rd_stat(rd_stat),
    .req_set(req_set), .req_clr(req_clr), .tc_done(tc_done),
    .mask_q(mask_o), .req_q(req_q), .tc_q(tc_q), .mode_q(mode_o)
  );

  dmac_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .mask_q(mask_o), .req_q(req_q), .grant_q(grant_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (mrst)   cmd_q <= '0;
    else if (cmd_we) cmd_q <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (rd_stat) begin
      rd_data[2*NUM_CH-1:0] = {req_q, tc_q};
    end else if (rd_mask) begin
      rd_data[NUM_CH-1:0] = mask_o;
    end
  end

  assign status_o  = {req_q, tc_q};
  assign cmd_o     = cmd_q;
  assign ptr_clr_o = pclr;
endmodule

// File: rtl/dmac_control_chk.sv
`timescale 1ns/1ps
module dmac_control_chk #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [3:0]          idx,
  input logic [DW-1:0]       wr_data,
  input logic [NUM_CH-1:0]   tc_done,
  input logic [NUM_CH-1:0]   mask_o,
  input logic [2*NUM_CH-1:0] status_o,
  input logic [DW-1:0]       cmd_o,
  input logic [NUM_CH-1:0]   grant_o
);
  localparam logic [DW-1:0] KEEP = DW'(4);

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R12
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |->
      ((grant_o & ~$past(mask_o) & $past(status_o[2*NUM_CH-1:NUM_CH])) == grant_o));

  // R2
  cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'h8 && ((wr_data & ~KEEP) != '0)) |=> $stable(cmd_o));

  // R7
  master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'hD) |=> (mask_o == '1 && cmd_o == '0));

  // R9
  stat_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == 4'h8 && tc_done == '0) |=> (status_o[NUM_CH-1:0] == '0));
endmodule

bind dmac_control dmac_control_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
  .wr_data(wr_data), .tc_done(tc_done), .mask_o(mask_o), .status_o(status_o),
  .cmd_o(cmd_o), .grant_o(grant_o)
);

// File: tb/dmac_control_tb.sv
`timescale 1ns/1ps
module dmac_control_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [3:0]  req_set = '0, req_clr = '0, tc_done = '0;
  logic [3:0]  mask_o, grant_o;
  logic [7:0]  status_o, cmd_o;
  logic [31:0] mode_o;
  logic        ptr_clr_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dmac_control u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
    .wr_data(wr_data), .rd_data(rd_data), .req_set(req_set), .req_clr(req_clr),
    .tc_done(tc_done), .mask_o(mask_o), .status_o(status_o), .cmd_o(cmd_o),
    .mode_o(mode_o), .ptr_clr_o(ptr_clr_o), .grant_o(grant_o)
  );

  // {index, data, expected mask, expected status, expected command}
  localparam logic [31:0] VEC [13] = '{
    32'hA00E0000, 32'hA02A0000, 32'h905A2000, 32'h907AA000, 32'h901A8000,
    32'h804A8004, 32'h810A8004, 32'h800A8000, 32'hF3558000, 32'hE0008000,
    32'hA0788000, 32'h80488004, 32'hD00F0000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; idx = i; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ext(input logic [3:0] s, input logic [3:0] c, input logic [3:0] t);
    @(negedge clk); req_set = s; req_clr = c; tc_done = t;
    @(negedge clk); req_set = '0; req_clr = '0; tc_done = '0;
  endtask

  function automatic string tag(input logic [3:0] i);
    case (i)
      4'h8: return "R2";
      4'h9: return "R3";
      4'hA: return "R4";
      4'hD: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask_o, 4'hF);
    chk("R1 status", status_o, 8'h00);
    chk("R1 cmd", cmd_o, 8'h00);
    chk("R1 mode", mode_o, 32'h0);
    chk("R1 grant", grant_o, 4'h0);

    for (int k = 0; k < 13; k++) begin
      wr(VEC[k][31:28], VEC[k][27:20]);
      chk({tag(VEC[k][31:28]), " mask"}, mask_o, VEC[k][19:16]);
      chk({tag(VEC[k][31:28]), " status"}, status_o, VEC[k][15:8]);
      chk({tag(VEC[k][31:28]), " cmd"}, cmd_o, VEC[k][7:0]);
    end

    // R5 mode bytes per channel
    wr(4'hB, 8'hE6);
    chk("R5 ch2", mode_o, 32'h00E60000);
    wr(4'hB, 8'h59);
    chk("R5 ch1", mode_o, 32'h00E65900);

    // R13 non-control indices ignored
    wr(4'h2, 8'h00);
    wr(4'h6, 8'h0F);
    wr(4'h0, 8'h04);
    chk("R13 mask", mask_o, 4'hF);
    chk("R13 cmd", cmd_o, 8'h00);
    chk("R13 status", status_o, 8'h00);
    @(negedge clk); rd_en = 1'b1; idx = 4'h7; #1;
    chk("R13 read", rd_data, 8'h00);
    @(negedge clk); rd_en = 1'b0;

    // R12 grant priority and one-cycle lag
    wr(4'hE, 8'h00);
    ext(4'b1100, 4'b0000, 4'b0000);
    chk("R11 set", status_o, 8'hC0);
    chk("R12 lag", grant_o, 4'h0);
    @(negedge clk);
    chk("R12 lowest", grant_o, 4'b0100);
    wr(4'hA, 8'h06);
    chk("R4 mask ch2", mask_o, 4'h4);
    @(negedge clk);
    chk("R12 masked moves up", grant_o, 4'b1000);

    // R11 release, and set beats release
    ext(4'b0000, 4'b1000, 4'b0000);
    chk("R11 release", status_o, 8'h40);
    @(negedge clk);
    chk("R12 none eligible", grant_o, 4'h0);
    ext(4'b0001, 4'b0001, 4'b0000);
    chk("R11 set wins", status_o, 8'h50);
    @(negedge clk);
    chk("R12 ch0", grant_o, 4'b0001);

    // R10 terminal count, R9 reads
    ext(4'b0000, 4'b0000, 4'b1010);
    chk("R10 tc", status_o, 8'h5A);
    @(negedge clk); rd_en = 1'b1; idx = 4'h8; #1;
    chk("R9 status read", rd_data, 8'h5A);
    @(negedge clk); rd_en = 1'b0;
    chk("R9 nibble cleared", status_o, 8'h50);
    @(negedge clk); rd_en = 1'b1; idx = 4'hF; #1;
    chk("R9 mask read", rd_data, 8'h04);
    idx = 4'hC; #1;
    chk("R9 other read", rd_data, 8'h00);
    @(negedge clk); rd_en = 1'b0;

    // R3 request write clears the channel's tc bit
    ext(4'b0000, 4'b0000, 4'b0001);
    chk("R10 tc0", status_o, 8'h51);
    wr(4'h9, 8'h04);
    chk("R3 tc cleared", status_o, 8'h50);

    // R10 tc beats same-cycle read clear
    @(negedge clk); rd_en = 1'b1; idx = 4'h8; tc_done = 4'b0100;
    @(negedge clk); rd_en = 1'b0; tc_done = '0;
    chk("R10 tc wins", status_o, 8'h54);

    // R6 pointer clear strobe
    @(negedge clk); wr_en = 1'b1; idx = 4'hC; wr_data = 8'h00; #1;
    chk("R6 idx C", ptr_clr_o, 1'b1);
    @(negedge clk); idx = 4'hB; wr_data = 8'h59; #1;
    chk("R6 idx B", ptr_clr_o, 1'b0);
    @(negedge clk); idx = 4'hD; wr_data = 8'h00; #1;
    chk("R6 idx D", ptr_clr_o, 1'b1);
    @(negedge clk); wr_en = 1'b0;
    chk("R7 mask", mask_o, 4'hF);
    chk("R7 status", status_o, 8'h00);
    chk("R7 mode kept", mode_o, 32'h00E65900);
    @(negedge clk);
    chk("R12 cleared", grant_o, 4'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule